// File: doc/BRIEF.md
# Atomic Access Address Generator and Classifier

This block forms the effective byte address of an atomic memory operation and classifies that address before any memory request leaves the core. It accepts a base held in one or two 32-bit registers and a 20-bit immediate. It builds the address in one of three ways:

- a 32-bit base plus a signed offset, wrapped to 32 bits;
- the immediate alone, taken as an unsigned absolute address;
- a 64-bit base plus a signed offset.

It then checks the address in parallel for three errors: it lies in the local or shared window, it is not aligned to the access size, or it lies outside the allocated region. Only the most important error is reported.

Window and region bounds arrive as inputs from whatever holds the configuration. Every bound describes a range that includes its base and excludes its limit. The result is registered, so each request presented with `in_valid` produces the address and the error flags one clock later, qualified by `out_valid`.

Top module: `atom_addr_chk`

## Requirements
- R1: With `mode` = 2'b00, `out_addr` is the 32-bit wrapped sum of `base_lo` and the sign-extended `offset`, with every bit above bit 31 zero.
- R2: With `mode` = 2'b01, `out_addr` is `offset` zero-extended, and `base_lo`/`base_hi` have no effect.
- R3: With `mode` = 2'b10 or 2'b11, `out_addr` is the 64-bit wrapped sum of {`base_hi`,`base_lo`} and the sign-extended `offset`.
- R4: With `size_64` = 0 the access needs `out_addr[1:0]` = 0, and with `size_64` = 1 it needs `out_addr[2:0]` = 0; otherwise the raw misalignment condition holds.
- R5: An address with `local_base` <= addr < `local_limit`, or with `shared_base` <= addr < `shared_limit`, raises the raw invalid-space condition.
- R6: An address outside `region_base` <= addr < `region_limit` raises the raw out-of-range condition.
- R7: At most one of `err_space`, `err_align`, `err_range` is set. Priority is space, then alignment, then range.
- R8: Results appear one cycle after the request. `out_valid` is `in_valid` delayed by one cycle. While `out_valid` is 0, `out_addr` and all the flags are 0, and reset clears them as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | 00 base+offset, 01 absolute, 1x extended |
| size_64 | input | 1 | 0 = 4-byte access, 1 = 8-byte access |
| base_lo | input | 32 | Base register (low half in extended mode) |
| base_hi | input | 32 | Upper base half, used in extended mode |
| offset | input | 20 | Immediate offset or absolute address |
| local_base | input | 64 | Local window start (inclusive) |
| local_limit | input | 64 | Local window end (exclusive) |
| shared_base | input | 64 | Shared window start (inclusive) |
| shared_limit | input | 64 | Shared window end (exclusive) |
| region_base | input | 64 | Allocated region start (inclusive) |
| region_limit | input | 64 | Allocated region end (exclusive) |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 64 | Effective byte address |
| err_space | output | 1 | Address hits local or shared window |
| err_align | output | 1 | Address misaligned for the size |
| err_range | output | 1 | Address outside allocated region |

## Verification
The bench builds the block with its default 20-bit offset and 32-bit register widths. These widths put both wrap points within reach of short directed cases: the 32-bit wrap of the narrow sum and the carry into the upper base half. Both a positive and a negative offset are applied in each of these cases. The windows and the region are placed so that an address can sit exactly on a base or a limit. Addresses are also built that meet two or three errors at once, which brings the priority order into view. Random requests, biased toward the window edges, then run alongside a behavioural model on every clock.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam int ATOM_ADDR_W = 64;

    typedef enum logic [1:0] {
        MODE_REG_OFS = 2'b00,
        MODE_ABS     = 2'b01,
        MODE_EXT     = 2'b10,
        MODE_EXT_ALT = 2'b11
    } addr_mode_e;

    typedef struct packed {
        logic                   err_space;
        logic                   err_align;
        logic                   err_range;
    } err_vec_t;

    typedef struct packed {
        logic                   valid;
        logic [ATOM_ADDR_W-1:0] addr;
        err_vec_t               err;
    } stage_t;

endpackage

// File: rtl/atom_addr_gen.sv
module atom_addr_gen
    import atom_pkg::*;
#(
    parameter int OFS_W = 20,
    parameter int REG_W = 32
) (
    input  logic [1:0]             mode,
    input  logic [REG_W-1:0]       base_lo,
    input  logic [REG_W-1:0]       base_hi,
    input  logic [OFS_W-1:0]       offset,
    output logic [ATOM_ADDR_W-1:0] addr
);
    localparam int PAD_OFS = ATOM_ADDR_W - OFS_W;
    localparam int PAD_REG = ATOM_ADDR_W - REG_W;

    logic [ATOM_ADDR_W-1:0] ofs_sext;
    logic [ATOM_ADDR_W-1:0] ofs_zext;
    logic [REG_W-1:0]       narrow_sum;
    logic [ATOM_ADDR_W-1:0] wide_sum;

    always_comb begin
        ofs_sext   = {{PAD_OFS{offset[OFS_W-1]}}, offset};
        ofs_zext   = {{PAD_OFS{1'b0}}, offset};
        narrow_sum = base_lo + ofs_sext[REG_W-1:0];
        wide_sum   = {base_hi, base_lo} + ofs_sext;
        unique case (addr_mode_e'(mode))
            MODE_REG_OFS: addr = {{PAD_REG{1'b0}}, narrow_sum};
            MODE_ABS:     addr = ofs_zext;
            default:      addr = wide_sum;
        endcase
    end
endmodule

// File: rtl/atom_range_hit.sv
module atom_range_hit
    import atom_pkg::*;
(
    input  logic [ATOM_ADDR_W-1:0] addr,
    input  logic [ATOM_ADDR_W-1:0] lo,
    input  logic [ATOM_ADDR_W-1:0] hi,
    output logic                   hit
);
    always_comb hit = (addr >= lo) && (addr < hi);
endmodule

// File: rtl/atom_err_pri.sv
module atom_err_pri
    import atom_pkg::*;
(
    input  logic     raw_space,
    input  logic     raw_align,
    input  logic     raw_range,
    output err_vec_t err
);
    always_comb begin
        err = '0;
        if (raw_space)      err.err_space = 1'b1;
        else if (raw_align) err.err_align = 1'b1;
        else if (raw_range) err.err_range = 1'b1;
    end
endmodule

// File: rtl/atom_addr_chk.sv
module atom_addr_chk
    import atom_pkg::*;
#(
    parameter int OFS_W = 20,
    parameter int REG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [1:0]             mode,
    input  logic                   size_64,
    input  logic [REG_W-1:0]       base_lo,
    input  logic [REG_W-1:0]       base_hi,
    input  logic [OFS_W-1:0]       offset,
    input  logic [ATOM_ADDR_W-1:0] local_base,
    input  logic [ATOM_ADDR_W-1:0] local_limit,
    input  logic [ATOM_ADDR_W-1:0] shared_base,
    input  logic [ATOM_ADDR_W-1:0] shared_limit,
    input  logic [ATOM_ADDR_W-1:0] region_base,
    input  logic [ATOM_ADDR_W-1:0] region_limit,
    output logic                   out_valid,
    output logic [ATOM_ADDR_W-1:0] out_addr,
    output logic                   err_space,
    output logic                   err_align,
    output logic                   err_range
);
    localparam int N_WIN   = 3;
    localparam int WIN_LOC = 0;
    localparam int WIN_SHR = 1;
    localparam int WIN_RGN = 2;

    logic [ATOM_ADDR_W-1:0] eff_addr;
    logic [ATOM_ADDR_W-1:0] win_lo [N_WIN];
    logic [ATOM_ADDR_W-1:0] win_hi [N_WIN];
    logic [N_WIN-1:0]       win_hit;
    logic                   raw_space;
    logic                   raw_align;
    logic                   raw_range;
    err_vec_t               err_sel;
    stage_t                 stage_d;
    stage_t                 stage_q;

    atom_addr_gen #(.OFS_W(OFS_W), .REG_W(REG_W)) u_gen (
        .mode    (mode),
        .base_lo (base_lo),
        .base_hi (base_hi),
        .offset  (offset),
        .addr    (eff_addr)
    );

    always_comb begin
        win_lo[WIN_LOC] = local_base;
        win_hi[WIN_LOC] = local_limit;
        win_lo[WIN_SHR] = shared_base;
        win_hi[WIN_SHR] = shared_limit;
        win_lo[WIN_RGN] = region_base;
        win_hi[WIN_RGN] = region_limit;
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        atom_range_hit u_hit (
            .addr (eff_addr),
            .lo   (win_lo[g]),
            .hi   (win_hi[g]),
            .hit  (win_hit[g])
        );
    end

    always_comb begin
        raw_space = win_hit[WIN_LOC] | win_hit[WIN_SHR];
        raw_range = ~win_hit[WIN_RGN];
        raw_align = size_64 ? (eff_addr[2:0] != 3'b000)
                            : (eff_addr[1:0] != 2'b00);
    end

    atom_err_pri u_pri (
        .raw_space (raw_space),
        .raw_align (raw_align),
        .raw_range (raw_range),
        .err       (err_sel)
    );

    always_comb begin
        stage_d = '0;
        if (in_valid) begin
            stage_d.valid = 1'b1;
            stage_d.addr  = eff_addr;
            stage_d.err   = err_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign out_valid = stage_q.valid;
    assign out_addr  = stage_q.addr;
    assign err_space = stage_q.err.err_space;
    assign err_align = stage_q.err.err_align;
    assign err_range = stage_q.err.err_range;

    assert_err_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_space, err_align, err_range}));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_addr == '0) && !err_space && !err_align && !err_range);

    assert_narrow_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode) == 2'b00) |-> (out_addr[ATOM_ADDR_W-1:REG_W] == '0));

    assert_abs_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mode) == 2'b01) |-> (out_addr[ATOM_ADDR_W-1:OFS_W] == '0));

    assert_space_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && raw_space) |=> err_space);
endmodule

// File: tb/atom_addr_chk_tb.sv
module atom_addr_chk_tb;
    localparam logic [63:0] LB = 64'h0000_0000_1000_0000;
    localparam logic [63:0] LL = 64'h0000_0000_1100_0000;
    localparam logic [63:0] SB = 64'h0000_0000_2000_0000;
    localparam logic [63:0] SL = 64'h0000_0000_2001_0000;
    localparam logic [63:0] RB = 64'h0000_0000_0000_0000;
    localparam logic [63:0] RL = 64'h0000_00F0_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        size_64 = 1'b0;
    logic [31:0] base_lo = '0;
    logic [31:0] base_hi = '0;
    logic [19:0] offset = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        err_space, err_align, err_range;

    int checks = 0;
    int errors = 0;

    logic [63:0] e_addr = '0;
    logic        e_valid = 1'b0, e_sp = 1'b0, e_al = 1'b0, e_rg = 1'b0;
    string       e_tag = "R8";

    always #10 clk = ~clk;

    atom_addr_chk u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .size_64(size_64),
        .base_lo(base_lo), .base_hi(base_hi), .offset(offset),
        .local_base(LB), .local_limit(LL), .shared_base(SB), .shared_limit(SL),
        .region_base(RB), .region_limit(RL),
        .out_valid(out_valid), .out_addr(out_addr),
        .err_space(err_space), .err_align(err_align), .err_range(err_range)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R8 valid", {63'd0, out_valid}, {63'd0, e_valid});
        chk({e_tag, " addr"}, out_addr, e_addr);
        chk("R5 err_space", {63'd0, err_space}, {63'd0, e_sp});
        chk("R4 err_align", {63'd0, err_align}, {63'd0, e_al});
        chk("R6 err_range", {63'd0, err_range}, {63'd0, e_rg});
        chk("R7 onehot", {63'd0, ($countones({err_space, err_align, err_range}) <= 1)}, 64'd1);
    endtask

    task automatic model(input logic v, input logic [1:0] m, input logic s64,
                         input logic [31:0] lo, input logic [31:0] hi, input logic [19:0] o);
        longint signed so;
        logic [63:0] a;
        logic [31:0] n;
        logic sp, al, rg;
        so = longint'($signed(o));
        if (m == 2'b00) begin
            n = lo + 32'(so);
            a = {32'd0, n};
            e_tag = "R1";
        end else if (m == 2'b01) begin
            a = {44'd0, o};
            e_tag = "R2";
        end else begin
            a = {hi, lo} + 64'(so);
            e_tag = "R3";
        end
        sp = (a >= LB && a < LL) || (a >= SB && a < SL);
        al = s64 ? (a % 8 != 0) : (a % 4 != 0);
        rg = !(a >= RB && a < RL);
        e_valid = v;
        e_addr  = v ? a : 64'd0;
        e_sp    = v && sp;
        e_al    = v && !sp && al;
        e_rg    = v && !sp && !al && rg;
        if (!v) e_tag = "R8";
    endtask

    task automatic step(input logic v, input logic [1:0] m, input logic s64,
                        input logic [31:0] lo, input logic [31:0] hi, input logic [19:0] o);
        @(negedge clk);
        compare_all();
        in_valid = v; mode = m; size_64 = s64; base_lo = lo; base_hi = hi; offset = o;
        model(v, m, s64, lo, hi, o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all();                  // R8 reset state
        rst = 1'b0;
        // R1: wrap at 32 bits, negative offset
        step(1, 2'b00, 0, 32'hFFFF_FFF0, 32'h0, 20'h00020);
        step(1, 2'b00, 0, 32'h0000_0100, 32'h5, 20'hFFE00);
        // R2: absolute, base ignored
        step(1, 2'b01, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 20'hFFF00);
        // R3: carry into upper half, both extended encodings
        step(1, 2'b10, 1, 32'hFFFF_FFF8, 32'h0000_0012, 20'h00010);
        step(1, 2'b11, 1, 32'h0000_0008, 32'h0000_0001, 20'hFFFF8);
        // R4: 8-byte access on 4-byte boundary; 4-byte access misaligned
        step(1, 2'b00, 1, 32'h0000_4004, 32'h0, 20'h00000);
        step(1, 2'b00, 0, 32'h0000_4002, 32'h0, 20'h00000);
        // R5: window bases inclusive, limits exclusive
        step(1, 2'b00, 0, 32'h1000_0000, 32'h0, 20'h00000);
        step(1, 2'b00, 0, 32'h1100_0000, 32'h0, 20'h00000);
        step(1, 2'b00, 0, 32'h2000_FFFC, 32'h0, 20'h00000);
        // R7: space beats misalignment; misalignment beats range
        step(1, 2'b00, 1, 32'h1000_0004, 32'h0, 20'h00000);
        step(1, 2'b10, 1, 32'h0000_0004, 32'h0000_00F0, 20'h00000);
        // R6: region limit exclusive
        step(1, 2'b10, 1, 32'h0000_0000, 32'h0000_00F0, 20'h00000);
        step(1, 2'b10, 1, 32'hFFFF_FFF8, 32'h0000_00EF, 20'h00000);
        // R8: idle cycle clears everything
        step(0, 2'b10, 1, 32'h1000_0001, 32'h0000_00F0, 20'h00001);
        for (int i = 0; i < 600; i++) begin
            logic [31:0] lo;
            logic [31:0] hi;
            lo = $urandom;
            hi = $urandom % 3 == 0 ? 32'h0000_00F0 : ($urandom % 2 == 0 ? 32'h0 : $urandom);
            case ($urandom % 4)
                0: lo = 32'h1000_0000 + ($urandom % 32) - 16;
                1: lo = 32'h2001_0000 + ($urandom % 32) - 16;
                default: ;
            endcase
            step(($urandom % 5) != 0, 2'($urandom), 1'($urandom), lo, hi, 20'($urandom));
        end
        step(0, 2'b00, 0, 32'h0, 32'h0, 20'h0);
        step(0, 2'b00, 0, 32'h0, 32'h0, 20'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule